// File: doc/BRIEF.md
# Four-Direction Edge Classifier

This block labels each pixel of an image stream with its dominant edge orientation. For every pixel site the caller presents the full 5x5 neighbourhood centred on that pixel as 25 parallel samples together with a valid strobe. The block correlates the neighbourhood with four fixed directional masks: horizontal, vertical, rising diagonal (+45 degrees) and falling diagonal (-45 degrees). It keeps the absolute value of each result as that direction's gradient strength.

The strongest of the four directions becomes the pixel's orientation. The block reports it three ways: as a one-hot flag vector, as a 2-bit direction code, and through the gradient magnitude of the winning mask. A new window can enter on every clock. Results leave in order after a fixed pipeline delay, so a raster scan of windows comes out as a raster scan of labels with no gaps added.

Window assembly from line stores, image-wide selection of significant edges and any later feature formation are done by other blocks.

Top module: `edge_dir_classifier`

## Requirements
- R1: A window accepted with `win_vld_i` high in cycle n produces `edge_vld_o` high in cycle n+3 and in no other cycle; windows may arrive on consecutive cycles and each yields exactly one result, in order.
- R2: Pixel (row r, column c), with r=0 the top row and c=0 the left column, occupies bits [(5*r+c)*PIX_W +: PIX_W] of `win_i`; pixels are unsigned.
- R3: The horizontal gradient is |sum of rows 0-1 minus sum of rows 3-4|; row 2 does not contribute.
- R4: The vertical gradient is |sum of columns 0-1 minus sum of columns 3-4|; column 2 does not contribute.
- R5: The +45 gradient is |sum of pixels with r+c<4 minus sum of pixels with r+c>4|.
- R6: The -45 gradient is |sum of pixels with c>r minus sum of pixels with r>c|.
- R7: On a valid result, `edge_grad_o` equals the largest of the four gradients and `edge_dir_o` names a direction holding that value, with code 0 = horizontal, 1 = vertical, 2 = +45, 3 = -45.
- R8: On a valid result, exactly one bit of `edge_flag_o` is set, and it is bit `edge_dir_o`.
- R9: When several directions share the largest gradient, the lowest code wins (horizontal, then vertical, then +45, then -45); a flat window therefore reports code 0 with gradient 0.
- R10: Whenever `edge_vld_o` is low, `edge_flag_o`, `edge_grad_o` and `edge_dir_o` are all zero.
- R11: A cycle with `rst` high discards every window in flight and any window presented in that cycle; the cycle after reset shows `edge_vld_o` low.
- R12: `edge_grad_o` is PIX_W+4 bits wide, enough for the largest possible gradient (10 x (2^PIX_W - 1), 2550 at PIX_W=8) without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| win_vld_i | input | 1 | Window on `win_i` is valid this cycle |
| win_i | input | 25*PIX_W | 5x5 neighbourhood, row-major, top-left pixel in the low bits |
| edge_vld_o | output | 1 | Classification result valid |
| edge_flag_o | output | 4 | One-hot direction flags, bit index equals the direction code |
| edge_grad_o | output | PIX_W+4 | Gradient magnitude of the winning direction |
| edge_dir_o | output | 2 | Winning direction code |

## Verification
The hardest case to reach from the ports is a tie between two or three directions. A random window almost never gives equal gradients, and the tie order shows only when it does. The stimulus builds ties on purpose from single bright pixels placed off the centre lines and from flat windows, where several masks see the same magnitude. It also walks a lone pixel over all 25 positions back to back. Every window, directed or random, is compared on every clock against a behavioural model that delays its expected results by three cycles, including across a reset asserted mid-stream.

// File: rtl/edge_dir_pkg.sv
package edge_dir_pkg;

    localparam int WIN_DIM  = 5;
    localparam int WIN_PIX  = WIN_DIM * WIN_DIM;
    localparam int WIN_MID  = WIN_DIM / 2;
    localparam int N_DIR    = 4;
    localparam int DIR_W    = $clog2(N_DIR);
    // taps on each signed side of any mask
    localparam int SIDE_CNT = (WIN_PIX - WIN_DIM) / 2;

    typedef enum logic [DIR_W-1:0] {
        DIR_HORZ = 2'd0,
        DIR_VERT = 2'd1,
        DIR_RISE = 2'd2,
        DIR_FALL = 2'd3
    } edge_dir_e;

    typedef struct packed {
        logic             vld;
        edge_dir_e        dir;
        logic [N_DIR-1:0] flag;
    } edge_tag_t;

    function automatic int grad_width(input int pix_w);
        return pix_w + $clog2(SIDE_CNT + 1);
    endfunction

    // +1 / -1 / 0 weight of tap (r,c) in the mask of direction dir.
    // Each mask compares a key against a pivot: below the pivot is the
    // positive side, above it the negative side, on it no weight.
    function automatic int tap_sign(input int dir, input int r, input int c);
        int key;
        int pivot;
        case (dir)
            0:       begin key = r;     pivot = WIN_MID;     end
            1:       begin key = c;     pivot = WIN_MID;     end
            2:       begin key = r + c; pivot = 2 * WIN_MID; end
            default: begin key = r - c; pivot = 0;           end
        endcase
        if (key < pivot)      return 1;
        else if (key > pivot) return -1;
        else                  return 0;
    endfunction

endpackage

// File: rtl/edge_dir_kernel.sv
module edge_dir_kernel
    import edge_dir_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int GRAD_W = 12,
    parameter int DIR    = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_i,
    input  logic                     vld_s1_i,
    input  logic [WIN_PIX*PIX_W-1:0] win_i,
    output logic [GRAD_W-1:0]        grad_o
);

    logic [GRAD_W-1:0] pos_sum, neg_sum;
    logic [GRAD_W-1:0] pos_q, neg_q;
    logic              unused_taps;

    // stage 1: split the mask into its positive and negative halves
    always_comb begin
        pos_sum     = '0;
        neg_sum     = '0;
        unused_taps = 1'b0;
        for (int r = 0; r < WIN_DIM; r++) begin
            for (int c = 0; c < WIN_DIM; c++) begin
                if (tap_sign(DIR, r, c) > 0)
                    pos_sum = pos_sum + GRAD_W'(win_i[(r*WIN_DIM+c)*PIX_W +: PIX_W]);
                else if (tap_sign(DIR, r, c) < 0)
                    neg_sum = neg_sum + GRAD_W'(win_i[(r*WIN_DIM+c)*PIX_W +: PIX_W]);
                else
                    unused_taps = unused_taps ^ (^win_i[(r*WIN_DIM+c)*PIX_W +: PIX_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            neg_q <= '0;
        end else if (vld_i) begin
            pos_q <= pos_sum;
            neg_q <= neg_sum;
        end
    end

    // stage 2: magnitude without a signed intermediate
    always_ff @(posedge clk) begin
        if (rst) begin
            grad_o <= '0;
        end else if (vld_s1_i) begin
            grad_o <= (pos_q >= neg_q) ? (pos_q - neg_q) : (neg_q - pos_q);
        end
    end

endmodule

// File: rtl/edge_dir_select.sv
module edge_dir_select
    import edge_dir_pkg::*;
#(
    parameter int GRAD_W = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         vld_i,
    input  logic [N_DIR-1:0][GRAD_W-1:0] grad_i,
    output logic                         vld_o,
    output logic [N_DIR-1:0]             flag_o,
    output logic [GRAD_W-1:0]            grad_o,
    output logic [DIR_W-1:0]             dir_o
);

    logic [DIR_W-1:0]  best;
    edge_tag_t         tag_q;
    logic [GRAD_W-1:0] grad_q;

    // strict compare in ascending code order keeps the lowest code on ties
    always_comb begin
        best = '0;
        for (int k = 1; k < N_DIR; k++) begin
            if (grad_i[k] > grad_i[best])
                best = DIR_W'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            grad_q <= '0;
        end else if (vld_i) begin
            tag_q.vld  <= 1'b1;
            tag_q.dir  <= edge_dir_e'(best);
            tag_q.flag <= N_DIR'(1) << best;
            grad_q     <= grad_i[best];
        end else begin
            tag_q  <= '0;
            grad_q <= '0;
        end
    end

    assign vld_o  = tag_q.vld;
    assign flag_o = tag_q.flag;
    assign dir_o  = tag_q.dir;
    assign grad_o = grad_q;

endmodule

// File: rtl/edge_dir_classifier.sv
module edge_dir_classifier
    import edge_dir_pkg::*;
#(
    parameter  int PIX_W  = 8,
    localparam int GRAD_W = grad_width(PIX_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     win_vld_i,
    input  logic [WIN_PIX*PIX_W-1:0] win_i,
    output logic                     edge_vld_o,
    output logic [N_DIR-1:0]         edge_flag_o,
    output logic [GRAD_W-1:0]        edge_grad_o,
    output logic [DIR_W-1:0]         edge_dir_o
);

    logic                         vld_s1, vld_s2;
    logic [N_DIR-1:0][GRAD_W-1:0] grad_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_s1 <= 1'b0;
            vld_s2 <= 1'b0;
        end else begin
            vld_s1 <= win_vld_i;
            vld_s2 <= vld_s1;
        end
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        edge_dir_kernel #(
            .PIX_W  (PIX_W),
            .GRAD_W (GRAD_W),
            .DIR    (d)
        ) u_kernel (
            .clk      (clk),
            .rst      (rst),
            .vld_i    (win_vld_i),
            .vld_s1_i (vld_s1),
            .win_i    (win_i),
            .grad_o   (grad_s2[d])
        );
    end

    edge_dir_select #(
        .GRAD_W (GRAD_W)
    ) u_select (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (vld_s2),
        .grad_i (grad_s2),
        .vld_o  (edge_vld_o),
        .flag_o (edge_flag_o),
        .grad_o (edge_grad_o),
        .dir_o  (edge_dir_o)
    );

endmodule

// File: rtl/edge_dir_checker.sv
module edge_dir_checker
    import edge_dir_pkg::*;
#(
    parameter int GRAD_W = 12
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         win_vld_i,
    input logic                         edge_vld_o,
    input logic [N_DIR-1:0]             edge_flag_o,
    input logic [GRAD_W-1:0]            edge_grad_o,
    input logic [DIR_W-1:0]             edge_dir_o,
    input logic [N_DIR-1:0][GRAD_W-1:0] grad_s2
);

    logic [N_DIR-1:0][GRAD_W-1:0] grad_prev;

    always_ff @(posedge clk) begin
        grad_prev <= grad_s2;
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        win_vld_i |-> ##3 edge_vld_o);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        edge_vld_o |-> $past(win_vld_i, 3));

    a_r7_is_max: assert property (@(posedge clk) disable iff (rst)
        edge_vld_o |-> (edge_grad_o >= grad_prev[0]) && (edge_grad_o >= grad_prev[1]) &&
                       (edge_grad_o >= grad_prev[2]) && (edge_grad_o >= grad_prev[3]) &&
                       (edge_grad_o == grad_prev[edge_dir_o]));

    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        edge_vld_o |-> ($countones(edge_flag_o) == 1) && edge_flag_o[edge_dir_o]);

    a_r9_low_code_wins: assert property (@(posedge clk) disable iff (rst)
        edge_vld_o |-> ((edge_dir_o < 2'd1) || (grad_prev[0] < edge_grad_o)) &&
                       ((edge_dir_o < 2'd2) || (grad_prev[1] < edge_grad_o)) &&
                       ((edge_dir_o < 2'd3) || (grad_prev[2] < edge_grad_o)));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !edge_vld_o |-> (edge_flag_o == '0) && (edge_grad_o == '0) && (edge_dir_o == '0));

    a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !edge_vld_o);

endmodule

bind edge_dir_classifier edge_dir_checker #(
    .GRAD_W (GRAD_W)
) u_edge_dir_checker (
    .clk         (clk),
    .rst         (rst),
    .win_vld_i   (win_vld_i),
    .edge_vld_o  (edge_vld_o),
    .edge_flag_o (edge_flag_o),
    .edge_grad_o (edge_grad_o),
    .edge_dir_o  (edge_dir_o),
    .grad_s2     (grad_s2)
);

// File: tb/tb_edge_dir_classifier.sv
module tb_edge_dir_classifier;

    localparam int PW = 8;
    localparam int NP = 25;
    localparam int WW = PW * NP;
    localparam int GW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          win_vld = 1'b0;
    logic [WW-1:0] win = '0;
    logic          edge_vld_o;
    logic [3:0]    edge_flag_o;
    logic [GW-1:0] edge_grad_o;
    logic [1:0]    edge_dir_o;

    edge_dir_classifier #(.PIX_W(PW)) dut (
        .clk         (clk),
        .rst         (rst),
        .win_vld_i   (win_vld),
        .win_i       (win),
        .edge_vld_o  (edge_vld_o),
        .edge_flag_o (edge_flag_o),
        .edge_grad_o (edge_grad_o),
        .edge_dir_o  (edge_dir_o)
    );

    always #4 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R11";

    // expected-result history: index k holds what was driven k+1 negedges ago
    logic          h_v [3] = '{1'b0, 1'b0, 1'b0};
    logic [WW-1:0] h_w [3];

    function automatic void ref_eval(input logic [WW-1:0] w, output int g, output int d);
        int s [4] = '{0, 0, 0, 0};
        for (int r = 0; r < 5; r++) begin
            for (int c = 0; c < 5; c++) begin
                int p = int'(w[(r*5+c)*PW +: PW]);
                if (r < 2) s[0] += p; else if (r > 2) s[0] -= p;
                if (c < 2) s[1] += p; else if (c > 2) s[1] -= p;
                if (r + c < 4) s[2] += p; else if (r + c > 4) s[2] -= p;
                if (c > r) s[3] += p; else if (r > c) s[3] -= p;
            end
        end
        for (int k = 0; k < 4; k++) if (s[k] < 0) s[k] = -s[k];
        d = 0;
        for (int k = 1; k < 4; k++) if (s[k] > s[d]) d = k;
        g = s[d];
    endfunction

    function automatic logic [WW-1:0] put(input logic [WW-1:0] w, input int r, input int c, input int v);
        logic [WW-1:0] o = w;
        o[(r*5+c)*PW +: PW] = PW'(v);
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int eg, ed;
        if (h_v[2]) begin
            ref_eval(h_w[2], eg, ed);
            chk(edge_vld_o === 1'b1, cur_req, "valid", int'(edge_vld_o), 1);
            chk(edge_grad_o === GW'(eg), cur_req, "gradient", int'(edge_grad_o), eg);
            chk(edge_dir_o === 2'(ed), cur_req, "direction", int'(edge_dir_o), ed);
            chk(edge_flag_o === 4'(1 << ed), "R8", "flags", int'(edge_flag_o), 1 << ed);
        end else begin
            chk(edge_vld_o === 1'b0, cur_req, "valid", int'(edge_vld_o), 0);
            chk(edge_flag_o === 4'd0 && edge_grad_o === '0 && edge_dir_o === 2'd0, "R10",
                "idle outputs", int'(edge_grad_o) + int'(edge_flag_o) + int'(edge_dir_o), 0);
        end
    endtask

    task automatic tick(input logic v, input logic [WW-1:0] w, input logic r);
        @(negedge clk);
        compare();
        h_v[2] = h_v[1]; h_w[2] = h_w[1];
        h_v[1] = h_v[0]; h_w[1] = h_w[0];
        h_v[0] = v;      h_w[0] = w;
        if (r) begin
            h_v[0] = 1'b0; h_v[1] = 1'b0; h_v[2] = 1'b0;
        end
        rst = r; win_vld = v; win = w;
    endtask

    task automatic send_one(input string req, input logic [WW-1:0] w);
        cur_req = req;
        tick(1'b1, w, 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [WW-1:0] w;
        // R11: reset state
        cur_req = "R11";
        for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b1);
        for (int i = 0; i < 2; i++) tick(1'b0, '0, 1'b0);

        // R3: bright top rows, then bright bottom rows (sign folded by magnitude)
        w = '0;
        for (int r = 0; r < 2; r++) for (int c = 0; c < 5; c++) w = put(w, r, c, 200);
        send_one("R3", w);
        w = '0;
        for (int r = 3; r < 5; r++) for (int c = 0; c < 5; c++) w = put(w, r, c, 200);
        send_one("R3", w);

        // R4: bright left columns
        w = '0;
        for (int r = 0; r < 5; r++) for (int c = 0; c < 2; c++) w = put(w, r, c, 180);
        send_one("R4", w);

        // R5: bright upper-left triangle r+c<4
        w = '0;
        for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) if (r + c < 4) w = put(w, r, c, 150);
        send_one("R5", w);

        // R6: bright upper-right triangle c>r
        w = '0;
        for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) if (c > r) w = put(w, r, c, 170);
        send_one("R6", w);

        // R9: flat window gives code 0; lone pixel at (2,0) ties vertical and both diagonals
        w = '0;
        for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) w = put(w, r, c, 77);
        send_one("R9", w);
        send_one("R9", put('0, 2, 0, 255));
        send_one("R9", put('0, 2, 4, 255));

        // R12: largest magnitude
        w = '0;
        for (int r = 0; r < 2; r++) for (int c = 0; c < 5; c++) w = put(w, r, c, 255);
        send_one("R12", w);

        // R2: lone pixel walked over every position, back to back
        cur_req = "R2";
        for (int p = 0; p < 25; p++) tick(1'b1, put('0, p / 5, p % 5, 90 + p), 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b0);

        // R1: random stream with gaps
        cur_req = "R1";
        for (int i = 0; i < 300; i++) begin
            logic [WW-1:0] rw;
            for (int k = 0; k < NP; k++) rw[k*PW +: PW] = PW'($urandom);
            tick(($urandom % 4) != 0, rw, 1'b0);
        end
        for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b0);

        // R7: binary windows with strong, varied edges, full rate
        cur_req = "R7";
        for (int i = 0; i < 200; i++) begin
            logic [WW-1:0] rw;
            for (int k = 0; k < NP; k++) rw[k*PW +: PW] = ($urandom % 2) ? PW'(255) : PW'(0);
            tick(1'b1, rw, 1'b0);
        end
        for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b0);

        // R11: reset in the middle of a stream drops in-flight and presented windows
        cur_req = "R11";
        tick(1'b1, put('0, 0, 0, 250), 1'b0);
        tick(1'b1, put('0, 4, 4, 250), 1'b0);
        tick(1'b1, put('0, 1, 3, 250), 1'b1);
        for (int i = 0; i < 4; i++) tick(1'b0, '0, 1'b0);
        tick(1'b1, put('0, 3, 0, 120), 1'b0);
        for (int i = 0; i < 4; i++) tick(1'b0, '0, 1'b0);

        summary();
        $finish;
    end

endmodule